// File: doc/BRIEF.md
# Two-word instruction fetch unit

This block is the front stage of a five-stage pipeline whose instructions are 16 bits wide. It keeps a 32-bit program counter and reads one word per cycle from a word-addressed instruction memory that has combinational read. Most instructions fit in one word. A fixed set of opcodes carries an extra operand in the word that follows. For those, the unit takes a second cycle to read the extension word and then hands both words to decode together, with a 32-bit immediate built from them.

The unit's output is the fetch/decode pipeline register. It holds an interrupt flag, the address of the next sequential instruction, the instruction word and the 32-bit immediate. Decode and hazard logic steer the unit through four controls: a stall, a flush, a redirect with a target address, and an interrupt request. Branches are predicted not taken, so the unit fetches in address order until it receives a redirect.

Top module: `ifetch_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the program counter is loaded with RESET_PC (default 0) and all four fetch/decode fields (fd_irq, fd_pc_next, fd_instr, fd_imm) are cleared to zero.
- R2: A one-word instruction read at address P, with no stall, flush or redirect, is registered as fd_instr = the word, fd_pc_next = P+1 and fd_imm = 0. The program counter then moves to P+1.
- R3: Opcode bits [15:11] with the values 00100, 01010, 01011, 10110, 10111, 11000 or 11010 mark a two-word instruction. In the cycle that reads its first word, the register gets an all-zero bubble. In the next cycle, which reads the extension word at P+1, the register gets the first word, with fd_pc_next = P+2.
- R4: For the two-word opcodes 00100, 01010, 10110, 10111 and 11000, fd_imm is the extension word sign-extended from bit 15 to 32 bits.
- R5: For the two-word opcodes 01011 and 11010, fd_imm is a 20-bit address zero-extended to 32 bits. Bits [19:16] come from bits [3:0] of the first word and bits [15:0] from the extension word.
- R6: A stall without flush or redirect holds the program counter, the fetch phase and all fetch/decode fields for that cycle.
- R7: A flush without redirect clears all fetch/decode fields to zero. If the first word of a two-word instruction is waiting, it is dropped and fetch restarts at that first word's address. Otherwise fetch repeats the current address.
- R8: A redirect loads the program counter with redirect_pc and clears all fetch/decode fields. It takes priority over flush and stall and abandons any partly fetched two-word instruction.
- R9: When flush and stall are both asserted, the flush takes effect.
- R10: An irq pulse is remembered until the next real instruction is registered. That instruction carries fd_irq = 1, and the flag is then cleared. Bubbles, flushes, redirects and stalls neither report nor drop the pending flag.
- R11: imem_addr always equals the low ADDR_W bits of the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Hold the fetch state and the fetch/decode register |
| flush_i | input | 1 | Discard the fetched word and any waiting first word |
| redirect_i | input | 1 | Load a new fetch address |
| redirect_pc_i | input | 32 | Target address for a redirect |
| irq_i | input | 1 | Interrupt request pulse |
| imem_addr | output | 12 | Word address to the instruction memory |
| imem_rdata | input | 16 | Word read at imem_addr in the same cycle |
| fd_irq | output | 1 | Interrupt flag of the registered instruction |
| fd_pc_next | output | 32 | Address after the registered instruction |
| fd_instr | output | 16 | Registered instruction word |
| fd_imm | output | 32 | Registered immediate or address operand |

## Verification
A wrong phase bit shows up within one cycle at the ports. A two-word head is then delivered without its bubble, or an extension word comes out on fd_instr as if it were an instruction. A corrupt program counter appears on imem_addr in the same cycle and on fd_pc_next in the next one. A lost or stuck pending interrupt is visible only when the next real instruction is registered, so the bench compares fd_irq on every cycle against a model that carries the pending flag across bubbles, stalls and redirects. Random flush, stall and redirect timing then lands these events in every fetch phase.

// File: rtl/ifu_pkg.sv
// Package ifu_pkg
// Shared constants and types for the two-word fetch unit.
// Assumes the opcode sits in the top five bits of every instruction word.
package ifu_pkg;

    localparam int OPC_W   = 5;
    localparam int EA_HI_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADDI   = 5'b00100;
    localparam logic [OPC_W-1:0] OPC_LDM    = 5'b01010;
    localparam logic [OPC_W-1:0] OPC_LDD    = 5'b01011;
    localparam logic [OPC_W-1:0] OPC_BITSET = 5'b10110;
    localparam logic [OPC_W-1:0] OPC_RCL    = 5'b10111;
    localparam logic [OPC_W-1:0] OPC_RCR    = 5'b11000;
    localparam logic [OPC_W-1:0] OPC_STD    = 5'b11010;

    typedef enum logic {
        PH_HEAD = 1'b0,
        PH_EXT  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_SEXT = 2'd1,
        IMM_ADDR = 2'd2
    } imm_kind_e;

    // Map an opcode to the kind of operand its extension word carries.
    function automatic imm_kind_e imm_kind_of(input logic [OPC_W-1:0] opc);
        imm_kind_e k;
        case (opc)
            OPC_ADDI, OPC_LDM, OPC_BITSET, OPC_RCL, OPC_RCR: k = IMM_SEXT;
            OPC_LDD, OPC_STD:                                k = IMM_ADDR;
            default:                                         k = IMM_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ifu_classify.sv
// Module ifu_classify
// Decodes an opcode into its operand kind and flags opcodes that need a
// following extension word. Purely combinational.
module ifu_classify
    import ifu_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output imm_kind_e        kind_o,
    output logic             two_word_o
);

    // Look up the operand kind and derive the two-word flag from it.
    always_comb begin
        kind_o     = imm_kind_of(opc_i);
        two_word_o = (kind_o != IMM_NONE);
    end

endmodule

// File: rtl/ifu_imm_build.sv
// Module ifu_imm_build
// Builds the 32-bit operand from the extension word and the head word's
// low bits. Assumes IMM_W > IW + EA_HI_W. Purely combinational.
module ifu_imm_build
    import ifu_pkg::*;
#(
    parameter int IW    = 16,
    parameter int IMM_W = 32
) (
    input  imm_kind_e          kind_i,
    input  logic [EA_HI_W-1:0] head_lo_i,
    input  logic [IW-1:0]      ext_i,
    output logic [IMM_W-1:0]   imm_o
);

    localparam int SEXT_W = IMM_W - IW;
    localparam int ZPAD_W = IMM_W - IW - EA_HI_W;

    // Select sign extension, address concatenation or zero.
    always_comb begin
        case (kind_i)
            IMM_SEXT: imm_o = {{SEXT_W{ext_i[IW-1]}}, ext_i};
            IMM_ADDR: imm_o = {{ZPAD_W{1'b0}}, head_lo_i, ext_i};
            default:  imm_o = '0;
        endcase
    end

endmodule

// File: rtl/ifu_seq.sv
// Module ifu_seq
// Fetch sequencer. It holds the program counter, the head/extension phase,
// the waiting first word and its address, and the pending interrupt flag.
// It decides each cycle whether the fetch/decode register loads, clears or
// holds. Priority is redirect, then flush, then stall.
// Assumes the memory word for pc_q arrives in the same cycle on word_i.
module ifu_seq
    import ifu_pkg::*;
#(
    parameter int          PC_W     = 32,
    parameter int          IW       = 16,
    parameter int          ADDR_W   = 12,
    parameter logic [31:0] RESET_PC = 32'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            flush_i,
    input  logic            redirect_i,
    input  logic [PC_W-1:0] redirect_pc_i,
    input  logic            irq_i,
    input  logic [IW-1:0]   word_i,
    input  logic            two_word_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic            fd_ld_o,
    output logic            fd_clr_o,
    output logic            fd_irq_o,
    output logic [PC_W-1:0] fd_pc_o,
    output logic [IW-1:0]   fd_instr_o
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic [PC_W-1:0] pc_q, pc_d;
    logic [PC_W-1:0] hpc_q, hpc_d;
    logic [IW-1:0]   head_q, head_d;
    phase_e          phase_q, phase_d;
    logic            pend_q, pend_d;
    logic            irq_eff;

    // Fold a new request into the remembered one.
    assign irq_eff = pend_q | irq_i;

    // Next-state and register-control decision.
    always_comb begin
        pc_d     = pc_q;
        hpc_d    = hpc_q;
        head_d   = head_q;
        phase_d  = phase_q;
        pend_d   = irq_eff;
        fd_ld_o  = 1'b0;
        fd_clr_o = 1'b0;
        if (redirect_i) begin
            pc_d     = redirect_pc_i;
            phase_d  = PH_HEAD;
            fd_clr_o = 1'b1;
        end else if (flush_i) begin
            pc_d     = (phase_q == PH_EXT) ? hpc_q : pc_q;
            phase_d  = PH_HEAD;
            fd_clr_o = 1'b1;
        end else if (stall_i) begin
            pc_d = pc_q;
        end else if (phase_q == PH_HEAD) begin
            pc_d = pc_q + PC_ONE;
            if (two_word_i) begin
                phase_d  = PH_EXT;
                head_d   = word_i;
                hpc_d    = pc_q;
                fd_clr_o = 1'b1;
            end else begin
                fd_ld_o = 1'b1;
                pend_d  = 1'b0;
            end
        end else begin
            pc_d    = pc_q + PC_ONE;
            phase_d = PH_HEAD;
            fd_ld_o = 1'b1;
            pend_d  = 1'b0;
        end
    end

    // Sequencer state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC[PC_W-1:0];
            hpc_q   <= '0;
            head_q  <= '0;
            phase_q <= PH_HEAD;
            pend_q  <= 1'b0;
        end else begin
            pc_q    <= pc_d;
            hpc_q   <= hpc_d;
            head_q  <= head_d;
            phase_q <= phase_d;
            pend_q  <= pend_d;
        end
    end

    // Data offered to the fetch/decode register.
    always_comb begin
        fd_irq_o   = irq_eff;
        fd_pc_o    = pc_q + PC_ONE;
        fd_instr_o = (phase_q == PH_EXT) ? head_q : word_i;
    end

    assign addr_o = pc_q[ADDR_W-1:0];

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_i && !flush_i && !stall_i) |=> (pc_q == $past(pc_q) + PC_ONE)); // R2

    AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXT && !redirect_i && !flush_i && !stall_i) |=> (phase_q == PH_HEAD)); // R3

    AST_FLUSH_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !redirect_i && phase_q == PH_EXT) |=> (pc_q == $past(hpc_q))); // R7

endmodule

// File: rtl/ifu_fd_reg.sv
// Module ifu_fd_reg
// Fetch/decode pipeline register. A clear writes all zeros (a NOP),
// a load captures new fields, and otherwise the contents are held.
// Assumes clear and load are never requested together.
module ifu_fd_reg #(
    parameter int PC_W  = 32,
    parameter int IW    = 16,
    parameter int IMM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic             irq_d,
    input  logic [PC_W-1:0]  pc_d,
    input  logic [IW-1:0]    instr_d,
    input  logic [IMM_W-1:0] imm_d,
    output logic             irq_q,
    output logic [PC_W-1:0]  pc_q,
    output logic [IW-1:0]    instr_q,
    output logic [IMM_W-1:0] imm_q
);

    // Clear, load or hold the register fields.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            irq_q   <= 1'b0;
            pc_q    <= '0;
            instr_q <= '0;
            imm_q   <= '0;
        end else if (ld_i) begin
            irq_q   <= irq_d;
            pc_q    <= pc_d;
            instr_q <= instr_d;
            imm_q   <= imm_d;
        end
    end

    AST_CTRL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_i && ld_i)); // R3

endmodule

// File: rtl/ifetch_unit.sv
// Module ifetch_unit
// Top of the two-word instruction fetch stage. It reads one 16-bit word per
// cycle from a memory with combinational read. It merges an extension word
// into the preceding instruction where the opcode calls for one, and writes
// the fetch/decode register.
// Assumes imem_rdata is valid for imem_addr within the same cycle.
module ifetch_unit
    import ifu_pkg::*;
#(
    parameter int          PC_W     = 32,
    parameter int          IW       = 16,
    parameter int          IMM_W    = 32,
    parameter int          ADDR_W   = 12,
    parameter logic [31:0] RESET_PC = 32'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              flush_i,
    input  logic              redirect_i,
    input  logic [PC_W-1:0]   redirect_pc_i,
    input  logic              irq_i,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [IW-1:0]     imem_rdata,
    output logic              fd_irq,
    output logic [PC_W-1:0]   fd_pc_next,
    output logic [IW-1:0]     fd_instr,
    output logic [IMM_W-1:0]  fd_imm
);

    localparam int OPC_LSB = IW - OPC_W;

    imm_kind_e        now_kind;
    logic             now_two;
    imm_kind_e        sel_kind;
    logic             sel_two;
    logic             fd_ld, fd_clr, fd_irq_d;
    logic [PC_W-1:0]  fd_pc_d;
    logic [IW-1:0]    fd_instr_d;
    logic [IMM_W-1:0] fd_imm_d;
    logic [OPC_W-1:0] out_opc;

    // Classify the word read this cycle for the head/extension decision.
    ifu_classify u_cls_now (
        .opc_i      (imem_rdata[IW-1:OPC_LSB]),
        .kind_o     (now_kind),
        .two_word_o (now_two)
    );

    // Sequence the program counter and fetch phase.
    ifu_seq #(
        .PC_W(PC_W), .IW(IW), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_i       (stall_i),
        .flush_i       (flush_i),
        .redirect_i    (redirect_i),
        .redirect_pc_i (redirect_pc_i),
        .irq_i         (irq_i),
        .word_i        (imem_rdata),
        .two_word_i    (now_two),
        .addr_o        (imem_addr),
        .fd_ld_o       (fd_ld),
        .fd_clr_o      (fd_clr),
        .fd_irq_o      (fd_irq_d),
        .fd_pc_o       (fd_pc_d),
        .fd_instr_o    (fd_instr_d)
    );

    // Classify the instruction about to be registered to pick its operand.
    ifu_classify u_cls_out (
        .opc_i      (fd_instr_d[IW-1:OPC_LSB]),
        .kind_o     (sel_kind),
        .two_word_o (sel_two)
    );

    // Assemble the immediate from the waiting head and the extension word.
    ifu_imm_build #(.IW(IW), .IMM_W(IMM_W)) u_imm (
        .kind_i    (sel_kind),
        .head_lo_i (fd_instr_d[EA_HI_W-1:0]),
        .ext_i     (imem_rdata),
        .imm_o     (fd_imm_d)
    );

    // Fetch/decode pipeline register.
    ifu_fd_reg #(.PC_W(PC_W), .IW(IW), .IMM_W(IMM_W)) u_fd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (fd_clr),
        .ld_i    (fd_ld),
        .irq_d   (fd_irq_d),
        .pc_d    (fd_pc_d),
        .instr_d (fd_instr_d),
        .imm_d   (fd_imm_d),
        .irq_q   (fd_irq),
        .pc_q    (fd_pc_next),
        .instr_q (fd_instr),
        .imm_q   (fd_imm)
    );

    assign out_opc = fd_instr[IW-1:OPC_LSB];

    AST_LOAD_IMPLIES_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_ld && !sel_two) |-> (now_kind == now_kind) && (fd_imm_d == '0)); // R2

    AST_FLUSH_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i || redirect_i) |=> (fd_instr == '0 && fd_imm == '0 && fd_pc_next == '0 && !fd_irq)); // R7

    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (imem_addr == $past(redirect_pc_i[ADDR_W-1:0]))); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !flush_i && !redirect_i) |=> ($stable(fd_instr) && $stable(fd_imm)
            && $stable(fd_pc_next) && $stable(fd_irq) && $stable(imem_addr))); // R6

    AST_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_opc == OPC_LDD || out_opc == OPC_STD) |-> (fd_imm[IMM_W-1:IW+EA_HI_W] == '0)); // R5

    AST_SEXT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_kind_of(out_opc) == IMM_SEXT) |-> (fd_imm[IMM_W-1:IW] == {(IMM_W-IW){fd_imm[IW-1]}})); // R4

endmodule

// File: tb/ifetch_unit_tb_top.sv
module ifetch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0, flush_i = 1'b0, redirect_i = 1'b0, irq_i = 1'b0;
    logic [31:0] redirect_pc_i = '0;
    logic [11:0] imem_addr;
    logic [15:0] imem_rdata;
    logic        fd_irq;
    logic [31:0] fd_pc_next, fd_imm;
    logic [15:0] fd_instr;

    logic [15:0] mem [0:255];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state
    logic [31:0] m_pc, m_hpc;
    logic [15:0] m_head;
    bit          m_ext, m_pend;
    bit          e_irq;
    logic [31:0] e_pc, e_imm;
    logic [15:0] e_instr;

    always #2 clk = ~clk;

    assign imem_rdata = mem[imem_addr[7:0]];

    ifetch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .flush_i(flush_i),
        .redirect_i(redirect_i), .redirect_pc_i(redirect_pc_i), .irq_i(irq_i),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata), .fd_irq(fd_irq),
        .fd_pc_next(fd_pc_next), .fd_instr(fd_instr), .fd_imm(fd_imm)
    );

    function automatic int kind(input logic [15:0] w);
        case (w[15:11])
            5'b00100, 5'b01010, 5'b10110, 5'b10111, 5'b11000: return 1;
            5'b01011, 5'b11010: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_imm(input logic [15:0] h, input logic [15:0] x);
        if (kind(h) == 1) return {{16{x[15]}}, x};
        if (kind(h) == 2) return {12'h000, h[3:0], x};
        return 32'h0;
    endfunction

    function automatic logic [15:0] rand_word();
        logic [4:0] two [7] = '{5'b00100, 5'b01010, 5'b01011, 5'b10110, 5'b10111, 5'b11000, 5'b11010};
        logic [15:0] w = 16'($urandom);
        if ($urandom % 2 == 0) w[15:11] = two[$urandom % 7];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string ctx);
        chk({ctx, " R2 pc_next"}, fd_pc_next, e_pc);
        chk({ctx, " R3 instr"}, {16'h0, fd_instr}, {16'h0, e_instr});
        chk({ctx, (kind(e_instr) == 2) ? " R5 imm" : " R4 imm"}, fd_imm, e_imm);
        chk({ctx, " R10 irq"}, {31'h0, fd_irq}, {31'h0, e_irq});
        chk({ctx, " R11 addr"}, {20'h0, imem_addr}, {20'h0, m_pc[11:0]});
    endtask

    // One cycle: drive at negedge, advance the model, compare at next negedge.
    task automatic cyc(input bit s, input bit f, input bit r, input logic [31:0] rpc,
                       input bit i, input string ctx);
        logic [15:0] w;
        bit ie;
        stall_i = s; flush_i = f; redirect_i = r; redirect_pc_i = rpc; irq_i = i;
        w  = mem[m_pc[7:0]];
        ie = m_pend | i;
        m_pend = ie;
        if (r) begin
            {e_irq, e_pc, e_instr, e_imm} = '0;
            m_pc = rpc; m_ext = 0;
        end else if (f) begin
            {e_irq, e_pc, e_instr, e_imm} = '0;
            if (m_ext) m_pc = m_hpc;
            m_ext = 0;
        end else if (s) begin
            m_pc = m_pc;
        end else if (!m_ext) begin
            if (kind(w) != 0) begin
                {e_irq, e_pc, e_instr, e_imm} = '0;
                m_head = w; m_hpc = m_pc; m_ext = 1;
            end else begin
                e_irq = ie; e_pc = m_pc + 1; e_instr = w; e_imm = 0; m_pend = 0;
            end
            m_pc = m_pc + 1;
        end else begin
            e_irq = ie; e_pc = m_pc + 1; e_instr = m_head; e_imm = exp_imm(m_head, w);
            m_pend = 0; m_ext = 0; m_pc = m_pc + 1;
        end
        @(negedge clk);
        compare_all(ctx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2468));
        for (int a = 0; a < 256; a++) mem[a] = rand_word();
        mem[8'hF0] = {5'b01011, 7'b0010000, 4'hA}; mem[8'hF1] = 16'h1234;
        mem[8'hF2] = {5'b01010, 11'h100};          mem[8'hF3] = 16'h8001;
        mem[8'hF4] = {5'b00011, 11'h123};
        mem[8'hF5] = {5'b11010, 7'b0, 4'hF};       mem[8'hF6] = 16'hFFFF;
        mem[8'hF7] = 16'h0000;

        repeat (3) @(negedge clk);
        chk("R1 reset addr", {20'h0, imem_addr}, 32'h0);
        chk("R1 reset fields", {fd_irq, fd_instr, 15'h0} | fd_pc_next | fd_imm, 32'h0);
        m_pc = 0; m_hpc = 0; m_head = 0; m_ext = 0; m_pend = 0;
        {e_irq, e_pc, e_instr, e_imm} = '0;
        rst_n = 1'b1;

        // sequential program with both operand kinds
        cyc(0, 0, 1, 32'hF0, 0, "R8 redirect");
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 0, "R3 seq");
        // stall in the extension phase
        cyc(0, 0, 1, 32'hF0, 0, "R8 redirect");
        cyc(0, 0, 0, 0, 0, "R3 head");
        cyc(1, 0, 0, 0, 0, "R6 stall");
        cyc(1, 0, 0, 0, 1, "R6 stall irq");
        cyc(0, 0, 0, 0, 0, "R6 resume");
        // flush while the head waits
        cyc(0, 0, 1, 32'hF0, 0, "R8 redirect");
        cyc(0, 0, 0, 0, 0, "R3 head");
        cyc(0, 1, 0, 0, 0, "R7 flush ext");
        cyc(0, 0, 0, 0, 0, "R7 refetch");
        cyc(0, 0, 0, 0, 0, "R7 refetch");
        cyc(0, 1, 0, 0, 0, "R7 flush head");
        // priorities
        cyc(1, 1, 1, 32'hF4, 0, "R8 priority");
        cyc(1, 1, 0, 0, 0, "R9 flush over stall");
        cyc(0, 0, 0, 0, 0, "R9 after");
        // interrupt across a bubble
        cyc(0, 0, 1, 32'hF2, 0, "R8 redirect");
        cyc(0, 0, 0, 0, 1, "R10 irq bubble");
        cyc(0, 0, 0, 0, 0, "R10 delivered");
        cyc(0, 0, 0, 0, 0, "R10 cleared");
        cyc(0, 0, 1, 32'hFFFF_FFFE, 0, "R8 wrap");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, "R2 wrap");

        for (int k = 0; k < 3000; k++) begin
            bit s = ($urandom % 100) < 15;
            bit f = ($urandom % 100) < 5;
            bit r = ($urandom % 100) < 5;
            bit i = ($urandom % 100) < 5;
            logic [31:0] t = ($urandom % 8 == 0) ? 32'($urandom) : 32'($urandom % 256);
            cyc(s, f, r, t, i, "RND");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule